// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block turns a single pixel clock into the complete horizontal and vertical raster timing of a VGA-style display. Two 12-bit position counters walk each line and each frame. A decode stage derives the sync pulses, the display-enable window and an inner drawing window. All outputs are registered. A renderer uses the X/Y coordinates and the enable flags to fetch pixels. The event strobes let a processor or a frame buffer act once per line, once per frame, and once at the start of vertical blanking.

The timing is chosen at elaboration. One preset gives 640x480 with a pixel clock near 25.175 MHz. A second preset gives 720x400 with a pixel clock near 35.5 MHz. A third setting takes free parameters for every porch, sync and active width. A border of configurable width and height lies inside the non-blanked area. It lets a picture smaller than the visible area sit centred, with no partial character rows or columns.

Top module: `vga_raster_gen`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the outputs after that edge take their idle values: both syncs at their inactive level, `displayEn`, `border`, `lineEnd`, `frameEnd` and `vblankIrq` low, and `pixelX` and `pixelY` zero.
- R2: The outputs after the k-th clock edge following reset release describe raster position k-1. Each line is walked from position 0 in this order: active pixels, front porch, sync, back porch. Each frame walks its lines in the same order.
- R3: `hsync` is at its active level only during the horizontal sync columns. The active level is low when horizontal polarity is negative and high otherwise.
- R4: `vsync` is at its active level only during the vertical sync lines, with the same polarity rule as R3 using the vertical polarity.
- R5: `displayEn` is high exactly when both the column and the line lie inside the active area.
- R6: `border` is high inside the active area within `BORDER_H` columns of its left or right edge, or within `BORDER_V` lines of its top or bottom edge. It is never high outside the active area.
- R7: Inside the inner window (active and not border), `pixelX` equals column minus `BORDER_H` and `pixelY` equals line minus `BORDER_V`. Both are zero everywhere else.
- R8: `lineEnd` is high for exactly one clock, on the last column of every line.
- R9: `frameEnd` is high for exactly one clock, on the last column of the last line of the frame, coinciding with `lineEnd`.
- R10: `vblankIrq` is high for exactly one clock, on the last column of the final active line, coinciding with `lineEnd`.
- R11: The counters are 12 bits wide. MODE 0 gives 800-clock lines with a 96-clock sync pulse and negative polarity on both syncs. MODE 1 gives 936-clock lines with a 72-clock negative horizontal sync and a positive vertical sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | output | 1 | Horizontal sync, mode polarity |
| vsync | output | 1 | Vertical sync, mode polarity |
| displayEn | output | 1 | High in the active (non-blanked) area |
| border | output | 1 | High in the border band inside the active area |
| lineEnd | output | 1 | One-clock strobe on the last column of a line |
| frameEnd | output | 1 | One-clock strobe on the last column of a frame |
| vblankIrq | output | 1 | One-clock strobe as vertical blanking begins |
| pixelX | output | 12 | Column inside the inner window, else zero |
| pixelY | output | 12 | Line inside the inner window, else zero |

## Verification
The three event strobes share cycles. `lineEnd` fires together with `frameEnd` on the final clock of the frame, and together with `vblankIrq` on the final clock of the last active line. A small custom raster is used, with an 11-line frame of 25-clock lines, so that both coincidences occur several times in a short run, including across a mid-frame reset. Each cycle is judged by comparing every output field against a position model. The model flags a strobe that arrives alone, arrives twice, or lands one cycle off its line.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

  localparam int CNT_W = 12;

  typedef struct packed {
    logic [CNT_W-1:0] hActive;
    logic [CNT_W-1:0] hFront;
    logic [CNT_W-1:0] hSync;
    logic [CNT_W-1:0] hBack;
    logic [CNT_W-1:0] vActive;
    logic [CNT_W-1:0] vFront;
    logic [CNT_W-1:0] vSync;
    logic [CNT_W-1:0] vBack;
    logic             hNeg;
    logic             vNeg;
  } timing_t;

  // strobes from control to datapath, all describe the current counter position
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
    logic vblankStart;
    logic hSyncZone;
    logic vSyncZone;
    logic dispArea;
    logic pixWin;
    logic rowWin;
  } strobes_t;

  function automatic timing_t modeTiming(int mode);
    timing_t t;
    if (mode == 1) begin
      t.hActive = 12'd720; t.hFront = 12'd36; t.hSync = 12'd72; t.hBack = 12'd108;
      t.vActive = 12'd400; t.vFront = 12'd1;  t.vSync = 12'd3;  t.vBack = 12'd42;
      t.hNeg = 1'b1; t.vNeg = 1'b0;
    end else begin
      t.hActive = 12'd640; t.hFront = 12'd16; t.hSync = 12'd96; t.hBack = 12'd48;
      t.vActive = 12'd480; t.vFront = 12'd10; t.vSync = 12'd2;  t.vBack = 12'd33;
      t.hNeg = 1'b1; t.vNeg = 1'b1;
    end
    return t;
  endfunction

endpackage

// File: rtl/vga_raster_ctrl.sv
module vga_raster_ctrl
  import vga_raster_pkg::*;
#(
  parameter timing_t TIM      = modeTiming(0),
  parameter int      BORDER_H = 0,
  parameter int      BORDER_V = 0
) (
  input  logic     clk,
  input  logic     rst,
  output strobes_t strb
);

  localparam logic [CNT_W-1:0] H_LAST     = TIM.hActive + TIM.hFront + TIM.hSync + TIM.hBack - 12'd1;
  localparam logic [CNT_W-1:0] V_LAST     = TIM.vActive + TIM.vFront + TIM.vSync + TIM.vBack - 12'd1;
  localparam logic [CNT_W-1:0] H_SYNC_LO  = TIM.hActive + TIM.hFront;
  localparam logic [CNT_W-1:0] H_SYNC_HI  = H_SYNC_LO + TIM.hSync;
  localparam logic [CNT_W-1:0] V_SYNC_LO  = TIM.vActive + TIM.vFront;
  localparam logic [CNT_W-1:0] V_SYNC_HI  = V_SYNC_LO + TIM.vSync;
  localparam logic [CNT_W-1:0] BH         = CNT_W'(BORDER_H);
  localparam logic [CNT_W-1:0] BV         = CNT_W'(BORDER_V);
  localparam logic [CNT_W-1:0] H_WIN_END  = TIM.hActive - BH;
  localparam logic [CNT_W-1:0] V_WIN_END  = TIM.vActive - BV;
  localparam logic [CNT_W-1:0] V_ACT_LAST = TIM.vActive - 12'd1;

  logic [CNT_W-1:0] hCount, vCount;
  logic hAct, vAct, colWin, rowWin;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (hCount == H_LAST) begin
      hCount <= '0;
      vCount <= (vCount == V_LAST) ? '0 : vCount + 12'd1;
    end else begin
      hCount <= hCount + 12'd1;
    end
  end

  always_comb begin
    hAct   = hCount < TIM.hActive;
    vAct   = vCount < TIM.vActive;
    colWin = (hCount >= BH) && (hCount < H_WIN_END);
    rowWin = (vCount >= BV) && (vCount < V_WIN_END);
    strb.lineEnd     = hCount == H_LAST;
    strb.frameEnd    = (hCount == H_LAST) && (vCount == V_LAST);
    strb.vblankStart = (hCount == H_LAST) && (vCount == V_ACT_LAST);
    strb.hSyncZone   = (hCount >= H_SYNC_LO) && (hCount < H_SYNC_HI);
    strb.vSyncZone   = (vCount >= V_SYNC_LO) && (vCount < V_SYNC_HI);
    strb.dispArea    = hAct && vAct;
    strb.pixWin      = colWin && rowWin;
    strb.rowWin      = rowWin;
  end

  // R8: a line wrap returns the column counter to zero
  a_r8_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (hCount == H_LAST) |=> (hCount == '0));
  // R9: a frame wrap returns both counters to the origin
  a_r9_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    strb.frameEnd |=> (hCount == '0 && vCount == '0));
  // R2: the line counter only moves on a line wrap
  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.lineEnd |=> $stable(vCount));

endmodule

// File: rtl/vga_raster_dp.sv
module vga_raster_dp
  import vga_raster_pkg::*;
#(
  parameter bit HNEG = 1'b1,
  parameter bit VNEG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         strb,
  output logic             hsync,
  output logic             vsync,
  output logic             displayEn,
  output logic             border,
  output logic             lineEnd,
  output logic             frameEnd,
  output logic             vblankIrq,
  output logic [CNT_W-1:0] pixelX,
  output logic [CNT_W-1:0] pixelY
);

  logic [CNT_W-1:0] xRun, yRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= HNEG;
      vsync     <= VNEG;
      displayEn <= 1'b0;
      border    <= 1'b0;
      lineEnd   <= 1'b0;
      frameEnd  <= 1'b0;
      vblankIrq <= 1'b0;
      pixelX    <= '0;
      pixelY    <= '0;
      xRun      <= '0;
      yRun      <= '0;
    end else begin
      hsync     <= strb.hSyncZone ^ HNEG;
      vsync     <= strb.vSyncZone ^ VNEG;
      displayEn <= strb.dispArea;
      border    <= strb.dispArea && !strb.pixWin;
      lineEnd   <= strb.lineEnd;
      frameEnd  <= strb.frameEnd;
      vblankIrq <= strb.vblankStart;
      if (strb.pixWin) begin
        pixelX <= xRun;
        pixelY <= yRun;
        xRun   <= xRun + 12'd1;
      end else begin
        pixelX <= '0;
        pixelY <= '0;
        xRun   <= '0;
      end
      if (strb.frameEnd)
        yRun <= '0;
      else if (strb.lineEnd && strb.rowWin)
        yRun <= yRun + 12'd1;
    end
  end

  a_r8_eol_single: assert property (@(posedge clk) disable iff (rst)
    lineEnd |=> !lineEnd);
  a_r9_eof_with_eol: assert property (@(posedge clk) disable iff (rst)
    frameEnd |-> lineEnd);
  a_r10_vbl_with_eol: assert property (@(posedge clk) disable iff (rst)
    vblankIrq |-> (lineEnd && !frameEnd));
  a_r6_border_inside: assert property (@(posedge clk) disable iff (rst)
    border |-> displayEn);
  a_r7_coord_zero: assert property (@(posedge clk) disable iff (rst)
    !(displayEn && !border) |-> (pixelX == '0 && pixelY == '0));
  a_r7_x_step: assert property (@(posedge clk) disable iff (rst)
    (displayEn && !border && $past(displayEn && !border)) |-> (pixelX == $past(pixelX) + 12'd1));

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_raster_pkg::*;
#(
  parameter int MODE       = 0,   // 0: 640x480, 1: 720x400, 2: custom below
  parameter int C_H_ACTIVE = 640,
  parameter int C_H_FRONT  = 16,
  parameter int C_H_SYNC   = 96,
  parameter int C_H_BACK   = 48,
  parameter int C_V_ACTIVE = 480,
  parameter int C_V_FRONT  = 10,
  parameter int C_V_SYNC   = 2,
  parameter int C_V_BACK   = 33,
  parameter bit C_H_NEG    = 1'b1,
  parameter bit C_V_NEG    = 1'b1,
  parameter int BORDER_H   = 8,
  parameter int BORDER_V   = 8
) (
  input  logic        clk,
  input  logic        rst,
  output logic        hsync,
  output logic        vsync,
  output logic        displayEn,
  output logic        border,
  output logic        lineEnd,
  output logic        frameEnd,
  output logic        vblankIrq,
  output logic [11:0] pixelX,
  output logic [11:0] pixelY
);

  localparam timing_t CUSTOM = '{
    hActive: CNT_W'(C_H_ACTIVE), hFront: CNT_W'(C_H_FRONT),
    hSync:   CNT_W'(C_H_SYNC),   hBack:  CNT_W'(C_H_BACK),
    vActive: CNT_W'(C_V_ACTIVE), vFront: CNT_W'(C_V_FRONT),
    vSync:   CNT_W'(C_V_SYNC),   vBack:  CNT_W'(C_V_BACK),
    hNeg:    C_H_NEG,            vNeg:   C_V_NEG};
  localparam timing_t TIM = (MODE == 2) ? CUSTOM : modeTiming(MODE);

  strobes_t strb;

  vga_raster_ctrl #(.TIM(TIM), .BORDER_H(BORDER_H), .BORDER_V(BORDER_V)) ctrl_i (
    .clk(clk), .rst(rst), .strb(strb));

  vga_raster_dp #(.HNEG(TIM.hNeg), .VNEG(TIM.vNeg)) dp_i (
    .clk(clk), .rst(rst), .strb(strb),
    .hsync(hsync), .vsync(vsync), .displayEn(displayEn), .border(border),
    .lineEnd(lineEnd), .frameEnd(frameEnd), .vblankIrq(vblankIrq),
    .pixelX(pixelX), .pixelY(pixelY));

endmodule

// File: tb/vga_raster_gen_tb.sv
module vga_raster_gen_tb_top;

  typedef struct {
    bit          inReset;
    logic        hs, vs, de, bd, eol, eof, vbl;
    logic [11:0] x, y;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic hsync, vsync, displayEn, border, lineEnd, frameEnd, vblankIrq;
  logic [11:0] pixelX, pixelY;

  // small custom raster: 25 clocks per line, 11 lines per frame
  vga_raster_gen #(
    .MODE(2), .C_H_ACTIVE(16), .C_H_FRONT(2), .C_H_SYNC(3), .C_H_BACK(4),
    .C_V_ACTIVE(6), .C_V_FRONT(1), .C_V_SYNC(2), .C_V_BACK(2),
    .C_H_NEG(1'b1), .C_V_NEG(1'b0), .BORDER_H(2), .BORDER_V(1)
  ) dut_i (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .displayEn(displayEn),
    .border(border), .lineEnd(lineEnd), .frameEnd(frameEnd), .vblankIrq(vblankIrq),
    .pixelX(pixelX), .pixelY(pixelY));

  logic p0hs, p0vs, p0de, p0bd, p0eol, p0eof, p0vbl, p1hs, p1vs, p1de, p1bd, p1eol, p1eof, p1vbl;
  logic [11:0] p0x, p0y, p1x, p1y;

  vga_raster_gen #(.MODE(0)) preset0_i (
    .clk(clk), .rst(rst), .hsync(p0hs), .vsync(p0vs), .displayEn(p0de), .border(p0bd),
    .lineEnd(p0eol), .frameEnd(p0eof), .vblankIrq(p0vbl), .pixelX(p0x), .pixelY(p0y));
  vga_raster_gen #(.MODE(1)) preset1_i (
    .clk(clk), .rst(rst), .hsync(p1hs), .vsync(p1vs), .displayEn(p1de), .border(p1bd),
    .lineEnd(p1eol), .frameEnd(p1eof), .vblankIrq(p1vbl), .pixelX(p1x), .pixelY(p1y));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // driver: model of the raster, one expected item per clock edge
  exp_t q[$];
  int pos = 0;
  always @(posedge clk) begin
    exp_t e;
    int h, v;
    bit win;
    cycles++;
    if (rst) begin
      e.inReset = 1'b1;
      e.hs = 1'b1; e.vs = 1'b0; e.de = 1'b0; e.bd = 1'b0;
      e.eol = 1'b0; e.eof = 1'b0; e.vbl = 1'b0; e.x = '0; e.y = '0;
      pos = 0;
    end else begin
      h = pos % 25;
      v = (pos / 25) % 11;
      win = (h >= 2 && h < 14 && v >= 1 && v < 5);
      e.inReset = 1'b0;
      e.hs  = !(h >= 18 && h < 21);
      e.vs  = (v >= 7 && v < 9);
      e.de  = (h < 16 && v < 6);
      e.bd  = e.de && !win;
      e.eol = (h == 24);
      e.eof = (h == 24 && v == 10);
      e.vbl = (h == 24 && v == 5);
      e.x   = win ? 12'(h - 2) : 12'd0;
      e.y   = win ? 12'(v - 1) : 12'd0;
      pos++;
    end
    q.push_back(e);
  end

  // monitor: compare each field away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.inReset) begin
        check("R1 hsync",     int'(hsync),     int'(e.hs));
        check("R1 vsync",     int'(vsync),     int'(e.vs));
        check("R1 displayEn", int'(displayEn), 0);
        check("R1 border",    int'(border),    0);
        check("R1 strobes",   int'({lineEnd, frameEnd, vblankIrq}), 0);
        check("R1 coords",    int'(pixelX) + int'(pixelY), 0);
      end else begin
        check("R3 hsync",     int'(hsync),     int'(e.hs));
        check("R4 vsync",     int'(vsync),     int'(e.vs));
        check("R5 displayEn", int'(displayEn), int'(e.de));
        check("R6 border",    int'(border),    int'(e.bd));
        check("R7 pixelX",    int'(pixelX),    int'(e.x));
        check("R7 pixelY",    int'(pixelY),    int'(e.y));
        check("R8 lineEnd",   int'(lineEnd),   int'(e.eol));
        check("R9 frameEnd",  int'(frameEnd),  int'(e.eof));
        check("R10 vblankIrq", int'(vblankIrq), int'(e.vbl));
      end
    end
  end

  // R11: preset line lengths, sync widths and polarities
  int c0 = 0, l0 = 0, c1 = 0, l1 = 0;
  bit s0 = 1'b0, s1 = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      c0 = 0; l0 = 0; s0 = 1'b0; c1 = 0; l1 = 0; s1 = 1'b0;
    end else begin
      c0++; c1++;
      if (!p0hs) l0++;
      if (!p1hs) l1++;
      if (p0eol) begin
        if (s0) begin
          check("R11 mode0 line length", c0, 800);
          check("R11 mode0 hsync width", l0, 96);
          check("R11 mode0 vsync idle",  int'(p0vs), 1);
        end
        c0 = 0; l0 = 0; s0 = 1'b1;
      end
      if (p1eol) begin
        if (s1) begin
          check("R11 mode1 line length", c1, 936);
          check("R11 mode1 hsync width", l1, 72);
          check("R11 mode1 vsync idle",  int'(p1vs), 0);
        end
        c1 = 0; l1 = 0; s1 = 1'b1;
      end
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;                      // R2: position counting starts here
    repeat (900) @(negedge clk);
    rst = 1'b1;                      // mid-frame reset, R1 again
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (1950) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule